// File: doc/BRIEF.md
# Multi-Lane Stereo Serial Audio Transmitter

This block sends 32-bit stereo audio over several serial data lanes at once. Software writes every sample to one data port, whatever lane it is for. The samples collect in a small FIFO. At the start of each audio frame, every active lane receives one left word and one right word. Each lane then shifts its two words out MSB first, left word before right word. One bit leaves on each bit-slot strobe, and each frame has 64 slots. A companion clock generator supplies the bit-slot strobe and the frame strobe. Each strobe is a one-cycle pulse in the system clock domain.

A staging engine collects one complete frame of words ahead of time. It reads them from the FIFO one word per cycle, in lane order, into a per-lane holding buffer. The lanes load from this buffer when the frame starts. If the buffer is incomplete at the start of a frame, every lane sends zeros for that frame and a sticky underflow flag is set. Each lane can be switched on or off on its own. Each lane also chooses its alignment: the MSB can sit on the frame's first slot, or it can be delayed by one slot, with the previous frame's last bit filling the gap.

Top module: `mlane_i2s_tx`

## Requirements
- R1: Register map, byte addresses. The data port is at 0x00. The global control word is at 0x04: bit 0 is the master enable, bits 23:13 hold the active lane count minus one (values above LANES-1 act as LANES), bit 24 is the data enable, and bit 31 is the underflow flag. Lane i has its control word at 0x80 + 0x20*i: bit 0 enables the lane, and bit 1 selects the delayed alignment. A read returns the addressed word on rd_data one clock after rd_addr is presented. All other bits and addresses read 0. After reset every register is 0.
- R2: Each frame takes 2*N words from the FIFO, where N is the active lane count. They are taken in the order lane 0 left, lane 0 right, lane 1 left, lane 1 right, and so on. Each lane sends its left word in the first 32 slots of the frame and its right word in the last 32, MSB first. A complete frame of words that is in the FIFO at least 2*N+4 clocks before the frame strobe goes out in that frame.
- R3: With the lane's bit 1 clear, the MSB of the left word appears on the lane's output in slot 0. Slot 0 is the bit slot that carries the frame strobe. The output changes on the clock edge that samples bit_tick high.
- R4: With the lane's bit 1 set, slot 0 carries the last bit (bit 0) of the previous frame's right word, or 0 if there was no previous frame. The MSB of the left word follows in slot 1, and bit 1 of the right word is in slot 63.
- R5: A lane whose index is at or above the active count, or whose enable bit is clear, drives 0. A disabled lane below the active count still consumes its pair, so the lanes above it keep their own words.
- R6: If a frame starts while the master and data enables are both set and the frame's words are not complete in the buffer, every lane sends zero words for that frame and the underflow flag sets. Words already in the FIFO stay there. The flag holds until a write to 0x04 with bit 31 set.
- R7: While the data enable is clear, no words leave the FIFO, the lanes send zero words, and the underflow flag does not set.
- R8: While the master enable is clear, the FIFO is held empty, data-port writes are dropped, the holding buffer is emptied and every lane drives 0. The next frame after re-enabling starts again at lane 0 left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | 32 | Registered read data |
| bit_tick | input | 1 | One-cycle pulse per bit slot |
| frame_tick | input | 1 | Marks the bit slot that opens a frame (valid with bit_tick) |
| sd_out | output | LANES | Serial data, one bit per lane |

## Verification
The assertions assume three things about the inputs. First, frame_tick is high only in a cycle where bit_tick is also high. Second, frame strobes are at least 2*N+4 clocks apart. Third, the lane count does not change while a frame's words are being staged. The bench produces the strobes itself: one bit slot every four clocks and a frame strobe on every 64th slot. It changes the lane count only while the master enable is off, and it writes each frame's words well before the next frame strobe.

// File: rtl/i2s_tx_pkg.sv
`timescale 1ns/1ps
package i2s_tx_pkg;
  typedef logic [31:0] word_t;

  localparam int ADDR_DATA  = 0;
  localparam int ADDR_GCTL  = 4;
  localparam int LANE_STRIDE = 32;

  localparam int G_MASTER  = 0;
  localparam int G_CNT_LO  = 13;
  localparam int G_CNT_HI  = 23;
  localparam int G_DATA_EN = 24;
  localparam int G_UFLOW   = 31;

  localparam int L_EN    = 0;
  localparam int L_DELAY = 1;
endpackage

// File: rtl/i2s_tx_fifo.sv
`timescale 1ns/1ps
module i2s_tx_fifo #(
  parameter int DEPTH = 32,
  parameter int W     = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       flush,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic [$clog2(DEPTH):0]     level
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp, rp;
  logic         full, do_push;

  assign level   = wp - rp;
  assign full    = (level == (AW+1)'(DEPTH));
  assign do_push = push && !full && !flush;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp[AW-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (pop) dout <= mem[rp[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (pop)     rp <= rp + 1'b1;
    end
  end

  assert_level_bound_R2: assert property (@(posedge clk) disable iff (rst)
    level <= (AW+1)'(DEPTH));
  assert_pop_nonempty_R2: assert property (@(posedge clk) disable iff (rst)
    pop |-> level != '0);
endmodule

// File: rtl/i2s_tx_stager.sv
`timescale 1ns/1ps
module i2s_tx_stager #(
  parameter int LANES = 4,
  parameter int DEPTH = 32
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                flush,
  input  logic                                go,
  input  logic [$clog2(2*LANES+1)-1:0]        need,
  input  logic [$clog2(DEPTH):0]              level,
  input  logic [31:0]                         q,
  input  logic                                consume,
  output logic                                pop,
  output logic                                staged,
  output logic [2*LANES-1:0][31:0]            words
);
  localparam int NW   = $clog2(2*LANES+1);
  localparam int IW   = $clog2(2*LANES);
  localparam int LVLW = $clog2(DEPTH) + 1;

  logic          busy, pend;
  logic [NW-1:0] iss, pidx;

  assign pop = busy;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      busy   <= 1'b0;
      pend   <= 1'b0;
      staged <= 1'b0;
      iss    <= '0;
      pidx   <= '0;
    end else begin
      pend <= busy;
      pidx <= iss;
      if (busy) begin
        iss <= iss + 1'b1;
        if (iss == need - NW'(1)) busy <= 1'b0;
      end else if (go && !staged && !pend && level >= LVLW'(need)) begin
        busy <= 1'b1;
        iss  <= '0;
      end
      if (consume) staged <= 1'b0;
      if (pend && pidx == need - NW'(1)) staged <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (pend) words[pidx[IW-1:0]] <= q;
  end

  // R2: a burst never starts while a frame is already held
  assert_no_overrun_R2: assert property (@(posedge clk) disable iff (rst)
    (staged && !consume) |=> !busy || $past(busy));
endmodule

// File: rtl/i2s_tx_lane.sv
`timescale 1ns/1ps
module i2s_tx_lane (
  input  logic        clk,
  input  logic        rst,
  input  logic        en,
  input  logic        delayed,
  input  logic        slot,
  input  logic        frame_start,
  input  logic        load_valid,
  input  logic [31:0] word_l,
  input  logic [31:0] word_r,
  output logic        sd
);
  logic [63:0] sh, nw;

  always_comb nw = load_valid ? {word_l, word_r} : 64'd0;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      sh <= '0;
      sd <= 1'b0;
    end else if (slot) begin
      if (frame_start) begin
        if (delayed) begin
          sd <= sh[63];
          sh <= nw;
        end else begin
          sd <= nw[63];
          sh <= {nw[62:0], 1'b0};
        end
      end else begin
        sd <= sh[63];
        sh <= {sh[62:0], 1'b0};
      end
    end
  end

  assert_lane_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    !en |=> !sd);
  assert_hold_between_slots_R3: assert property (@(posedge clk) disable iff (rst)
    (en && !slot && $past(en)) |=> $stable(sd));
endmodule

// File: rtl/mlane_i2s_tx.sv
`timescale 1ns/1ps
module mlane_i2s_tx
  import i2s_tx_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int DEPTH  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  input  logic              bit_tick,
  input  logic              frame_tick,
  output logic [LANES-1:0]  sd_out
);
  localparam int NW        = $clog2(2*LANES+1);
  localparam int LVLW      = $clog2(DEPTH) + 1;
  localparam int LANE_BASE = (1 << $clog2(LANES)) * LANE_STRIDE;

  logic              master, den, uflow;
  logic [10:0]       cnt_field;
  logic [LANES-1:0]  lane_en, lane_dly, lane_on;
  logic [NW-1:0]     act, need;
  logic              gwr, push, fstart, consume, staged, pop;
  logic [LVLW-1:0]   level;
  logic [31:0]       q;
  logic [2*LANES-1:0][31:0] stg_words;

  assign gwr     = wr_en && (wr_addr == ADDR_W'(ADDR_GCTL));
  assign push    = wr_en && (wr_addr == ADDR_W'(ADDR_DATA)) && master;
  assign fstart  = bit_tick && frame_tick;
  assign consume = fstart && master && den && staged;

  always_comb begin
    if (cnt_field >= 11'(LANES)) act = NW'(LANES);
    else                         act = NW'(cnt_field) + NW'(1);
    need = act << 1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      master    <= 1'b0;
      den       <= 1'b0;
      cnt_field <= '0;
      uflow     <= 1'b0;
    end else begin
      if (gwr) begin
        master    <= wr_data[G_MASTER];
        den       <= wr_data[G_DATA_EN];
        cnt_field <= wr_data[G_CNT_HI:G_CNT_LO];
        if (wr_data[G_UFLOW]) uflow <= 1'b0;
      end
      if (fstart && master && den && !staged) uflow <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lane_en  <= '0;
      lane_dly <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < LANES; i++) begin
        if (wr_addr == ADDR_W'(LANE_BASE + LANE_STRIDE*i)) begin
          lane_en[i]  <= wr_data[L_EN];
          lane_dly[i] <= wr_data[L_DELAY];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      rd_data <= '0;
      if (rd_addr == ADDR_W'(ADDR_GCTL))
        rd_data <= {uflow, 6'd0, den, cnt_field, 12'd0, master};
      for (int i = 0; i < LANES; i++) begin
        if (rd_addr == ADDR_W'(LANE_BASE + LANE_STRIDE*i))
          rd_data <= {30'd0, lane_dly[i], lane_en[i]};
      end
    end
  end

  i2s_tx_fifo #(.DEPTH(DEPTH), .W(32)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .flush (!master),
    .push  (push),
    .din   (wr_data),
    .pop   (pop),
    .dout  (q),
    .level (level)
  );

  i2s_tx_stager #(.LANES(LANES), .DEPTH(DEPTH)) u_stager (
    .clk     (clk),
    .rst     (rst),
    .flush   (!master),
    .go      (master && den),
    .need    (need),
    .level   (level),
    .q       (q),
    .consume (consume),
    .pop     (pop),
    .staged  (staged),
    .words   (stg_words)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_on[g] = master && lane_en[g] && (act > NW'(g));
    i2s_tx_lane u_lane (
      .clk         (clk),
      .rst         (rst),
      .en          (lane_on[g]),
      .delayed     (lane_dly[g]),
      .slot        (bit_tick),
      .frame_start (fstart),
      .load_valid  (consume),
      .word_l      (stg_words[2*g]),
      .word_r      (stg_words[2*g+1]),
      .sd          (sd_out[g])
    );
  end

  assert_flush_R8: assert property (@(posedge clk) disable iff (rst)
    !master |=> level == '0);
  assert_no_draw_R7: assert property (@(posedge clk) disable iff (rst)
    (!den && !pop) |=> !pop);
  assert_uflow_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (uflow && !(gwr && wr_data[G_UFLOW])) |=> uflow);
  assert_quiet_off_R8: assert property (@(posedge clk) disable iff (rst)
    !master |=> sd_out == '0);
endmodule

// File: tb/sim_mlane_i2s_tx.sv
`timescale 1ns/1ps
module sim_mlane_i2s_tx;
  localparam int LANES = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        bit_tick = 1'b0;
  logic        frame_tick = 1'b0;
  logic [LANES-1:0] sd_out;

  int nchk = 0;
  int nerr = 0;
  logic [63:0] cap [LANES];
  logic [31:0] rv;

  always #10 clk = ~clk;

  mlane_i2s_tx #(.LANES(LANES), .DEPTH(32), .ADDR_W(8)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .bit_tick(bit_tick),
    .frame_tick(frame_tick), .sd_out(sd_out)
  );

  function automatic logic [31:0] gctl(input bit m, input bit d, input int lanes);
    return (32'(d) << 24) | (32'(lanes - 1) << 13) | 32'(m);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_frame();
    for (int s = 0; s < 64; s++) begin
      bit_tick = 1'b1;
      frame_tick = (s == 0);
      @(negedge clk);
      bit_tick = 1'b0;
      frame_tick = 1'b0;
      for (int l = 0; l < LANES; l++) cap[l][63-s] = sd_out[l];
      repeat (3) @(negedge clk);
    end
  endtask

  // lc: two bits per lane {delay, enable}
  task automatic cfg(input int lanes, input bit d, input logic [7:0] lc);
    wr(8'h04, 32'h8000_0000);
    for (int l = 0; l < LANES; l++) wr(8'(8'h80 + 8'h20*l), {30'd0, lc[2*l+1 -: 2]});
    wr(8'h04, gctl(1'b1, d, lanes));
    idle(2);
  endtask

  task automatic t_reset();
    chk("R1 reset sd_out", 64'(sd_out), 64'd0);
    rd(8'h04, rv); chk("R1 reset global", 64'(rv), 64'd0);
    rd(8'h80, rv); chk("R1 reset lane0", 64'(rv), 64'd0);
  endtask

  task automatic t_regs();
    wr(8'hC0, 32'hFFFF_FFFF);
    rd(8'hC0, rv); chk("R1 lane2 readback", 64'(rv), 64'd3);
    wr(8'h04, gctl(1'b0, 1'b1, 3));
    rd(8'h04, rv); chk("R1 global readback", 64'(rv), 64'(gctl(1'b0, 1'b1, 3)));
    rd(8'h08, rv); chk("R1 unmapped reads zero", 64'(rv), 64'd0);
  endtask

  task automatic t_lj();
    logic [31:0] a = 32'hA5C3_0F81, b = 32'h1234_5679;
    cfg(1, 1'b1, 8'b01_01_01_01);
    wr(8'h00, a); wr(8'h00, b);
    idle(20);
    run_frame();
    chk("R3 left-justified lane0", cap[0], {a, b});
    chk("R5 inactive lane1 low", cap[1], 64'd0);
    chk("R5 inactive lane3 low", cap[3], 64'd0);
  endtask

  task automatic t_delay();
    logic [31:0] a = 32'h8001_F00D, b = 32'h0BAD_CAF3, c = 32'hC001_D00D, d = 32'h7654_3210;
    cfg(1, 1'b1, 8'b00_00_00_11);
    wr(8'h00, a); wr(8'h00, b); wr(8'h00, c); wr(8'h00, d);
    idle(20);
    run_frame();
    chk("R4 first frame delayed", cap[0], {1'b0, a, b[31:1]});
    run_frame();
    chk("R4 carries previous right LSB", cap[0], {b[0], c, d[31:1]});
  endtask

  task automatic t_multi();
    logic [31:0] w [6];
    for (int k = 0; k < 6; k++) w[k] = 32'h1357_9BDF ^ (32'(k + 1) * 32'h1111_0101);
    cfg(3, 1'b1, 8'b01_01_00_01);
    for (int k = 0; k < 6; k++) wr(8'h00, w[k]);
    idle(20);
    run_frame();
    chk("R2 lane0 pair", cap[0], {w[0], w[1]});
    chk("R5 disabled lane1 low", cap[1], 64'd0);
    chk("R5 lane2 keeps own pair", cap[2], {w[4], w[5]});
    chk("R5 lane3 above count low", cap[3], 64'd0);
  endtask

  task automatic t_uflow();
    logic [31:0] x [4];
    for (int k = 0; k < 4; k++) x[k] = 32'hF0E1_D2C3 + 32'(k * 32'h0101_0101);
    cfg(2, 1'b1, 8'b00_00_01_01);
    for (int k = 0; k < 3; k++) wr(8'h00, x[k]);
    idle(20);
    run_frame();
    chk("R6 underflow lane0 zero", cap[0], 64'd0);
    chk("R6 underflow lane1 zero", cap[1], 64'd0);
    rd(8'h04, rv); chk("R6 flag set", 64'(rv[31]), 64'd1);
    wr(8'h00, x[3]);
    idle(20);
    run_frame();
    chk("R6 words kept lane0", cap[0], {x[0], x[1]});
    chk("R6 words kept lane1", cap[1], {x[2], x[3]});
    rd(8'h04, rv); chk("R6 flag sticky", 64'(rv[31]), 64'd1);
    wr(8'h04, gctl(1'b1, 1'b1, 2) | 32'h8000_0000);
    rd(8'h04, rv); chk("R6 flag cleared", 64'(rv), 64'(gctl(1'b1, 1'b1, 2)));
  endtask

  task automatic t_den();
    logic [31:0] y0 = 32'h5A5A_0001, y1 = 32'hA5A5_8000;
    cfg(1, 1'b0, 8'b00_00_00_01);
    wr(8'h00, y0); wr(8'h00, y1);
    idle(20);
    run_frame();
    chk("R7 no data while disabled", cap[0], 64'd0);
    rd(8'h04, rv); chk("R7 no underflow", 64'(rv[31]), 64'd0);
    wr(8'h04, gctl(1'b1, 1'b1, 1));
    idle(20);
    run_frame();
    chk("R7 words held then sent", cap[0], {y0, y1});
  endtask

  task automatic t_flush();
    logic [31:0] z0 = 32'hDEAD_BEEF, z1 = 32'h0F0F_1234;
    cfg(1, 1'b0, 8'b00_00_00_01);
    wr(8'h00, 32'h1111_1111); wr(8'h00, 32'h2222_2222);
    wr(8'h04, 32'h0);
    chk("R8 output low when off", 64'(sd_out), 64'd0);
    wr(8'h00, 32'h3333_3333); wr(8'h00, 32'h4444_4444);
    wr(8'h04, gctl(1'b1, 1'b1, 1));
    idle(20);
    run_frame();
    chk("R8 flushed frame zero", cap[0], 64'd0);
    rd(8'h04, rv); chk("R8 flush causes underflow", 64'(rv[31]), 64'd1);
    wr(8'h00, z0); wr(8'h00, z1);
    idle(20);
    run_frame();
    chk("R8 restart at lane0 left", cap[0], {z0, z1});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_lj();
    t_delay();
    t_multi();
    t_uflow();
    t_den();
    t_flush();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #3_000_000;
    nchk++;
    nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule